// File: doc/BRIEF.md
# Five-Source Host Interrupt Controller

This block gathers interrupt events from five on-chip sources and turns them into a single interrupt request for the host CPU. The sources are the video timebase, the graphics processor, the object processor, the periodic timer and an external peripheral chip. Each event sets a sticky pending flag. A flag raises the request only while its source is enabled.

Software uses two word registers. The control register holds the per-source enables in its low byte and one-shot clear bits in its high byte. A read of that address returns the pending flags, not the value last written. A second register is write-only. Writing it, with any data, allows a new request once the previous one has been serviced.

Each request is held until the software has cleared every enabled cause that is pending. After that, no further request is raised until the resume register is written. This keeps one service routine from being entered twice.

Top module: `irq_ctl_top`

## Requirements
- R1: After a synchronous active-low reset, every pending flag is 0, every enable is 0, `cpu_irq` is low and requests are not held off.
- R2: A one on `src_evt[i]` in a cycle sets pending flag i at the next clock edge, whether or not source i is enabled. The source order is: bit 0 video timebase, bit 1 graphics processor, bit 2 object processor, bit 3 periodic timer, bit 4 external peripheral. `rd_data` shows the pending flags in bits 4:0 and zero in bits 15:5.
- R3: A write to the control address (`reg_addr`=0) with bit 8+i of the data set clears pending flag i. A zero in bit 8+i leaves flag i unchanged.
- R4: If an event and a clear strobe for the same source fall in one cycle, the flag ends up set.
- R5: Every write to the control address loads the enables from data bits 4:0. Other accesses leave the enables unchanged. A pending source whose enable is 0, for example the periodic timer with bit 3 clear, never raises `cpu_irq`.
- R6: While requests are not held off, `cpu_irq` rises one clock edge after any source is both pending and enabled. It stays high until no source is both pending and enabled, and falls one edge after that.
- R7: Once `cpu_irq` has fallen, it stays low even if new enabled events arrive, until a write to the resume address (`reg_addr`=1). The request may then rise again, two edges after the write is taken.
- R8: A write to the resume address does not touch the pending flags or the enables, whatever data it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 5 | Event pulses, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = resume register |
| reg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Pending flags in bits 4:0 |
| cpu_irq | output | 1 | Interrupt request to the host CPU |

## Verification
Two functions can fall in the same cycle: a source event setting a flag, and a control write clearing that same flag. The bench drives the graphics-processor event and a control write with bit 9 set on the same clock edge. The enables are zero during this test, so the request output stays out of it. The flag is then read back, and it must still be set. A second case sends a resume write carrying all ones while a cause is already pending. The pending readback and the timing of the request show that only the hold-off was released.

// File: rtl/irq_ctl_pkg.sv
// Package: shared constants and types for the host interrupt controller.
// Assumes five sources with fixed bit order; register width is one word.
package irq_ctl_pkg;
    localparam int NSRC    = 5;
    localparam int REG_W   = 16;
    localparam int CLR_OFS = 8;   // first clear-strobe bit in the control word

    localparam int SRC_VIDEO = 0;
    localparam int SRC_GPU   = 1;
    localparam int SRC_OBJ   = 2;
    localparam int SRC_TIMER = 3;
    localparam int SRC_EXT   = 4;

    typedef enum logic [1:0] {
        GATE_OPEN   = 2'd0,   // ready to raise a request
        GATE_ASSERT = 2'd1,   // request driven to the host
        GATE_WAIT   = 2'd2    // serviced, waiting for resume
    } gate_state_e;
endpackage

// File: rtl/irq_regif.sv
// Module: irq_regif
// Decodes register writes into the enable register, per-source clear
// strobes and a resume pulse, and forms the read-back word from the
// pending flags. Assumes single-cycle write strobes; reads have no side effect.
module irq_regif
    import irq_ctl_pkg::*;
#(
    parameter int N_SRC   = NSRC,
    parameter int DATA_W  = REG_W,
    parameter int CLR_LSB = CLR_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_SRC-1:0]  pending,
    output logic [N_SRC-1:0]  enable_q,
    output logic [N_SRC-1:0]  clr_strobe,
    output logic              resume_pulse,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - N_SRC;

    logic ctl_wr;
    logic unused_wdata;

    // Decode which register the write is aimed at.
    always_comb begin
        ctl_wr       = wr && !addr;
        resume_pulse = wr && addr;
    end

    // Clear strobes come from the high byte on control writes only.
    always_comb begin
        clr_strobe = ctl_wr ? wdata[CLR_LSB +: N_SRC] : '0;
    end

    // Enable register: reloaded from the low bits on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (ctl_wr)
            enable_q <= wdata[N_SRC-1:0];
    end

    // Read-back returns pending status, zero-extended.
    always_comb begin
        rdata = {{PAD_W{1'b0}}, pending};
    end

    assign unused_wdata = ^wdata;

    // R5: enables only move on a control write
    a_r5_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && !addr) |=> $stable(enable_q));
    // R5: a control write loads the low bits
    a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !addr) |=> enable_q == $past(wdata[N_SRC-1:0]));
endmodule

// File: rtl/irq_pending_bank.sv
// Module: irq_pending_bank
// One sticky pending flag per source. An event sets a flag and a clear
// strobe resets it; when both arrive together the set takes priority.
module irq_pending_bank
    import irq_ctl_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        // Sticky flag for source i, set dominant over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else if (evt[i])
                pend_q[i] <= 1'b1;
            else if (clr[i])
                pend_q[i] <= 1'b0;
        end

        // R2/R4: an event always leaves the flag set
        a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> pend_q[i]);
        // R3: a lone clear strobe empties the flag
        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !pend_q[i]);
        // R2: a flag never rises without an event
        a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[i] && !evt[i]) |=> !pend_q[i]);
    end
endmodule

// File: rtl/irq_gate.sv
// Module: irq_gate
// Drives the host request. Raises it when any enabled cause is pending,
// holds it until all such causes are gone, then blocks new requests
// until a resume pulse. A resume outside the waiting state is a no-op.
module irq_gate
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_any,
    input  logic resume,
    output logic req
);
    gate_state_e state_q, state_d;

    // Next-state selection for the request gate.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN:   if (active_any) state_d = GATE_ASSERT;
            GATE_ASSERT: if (!active_any) state_d = GATE_WAIT;
            GATE_WAIT:   if (resume) state_d = GATE_OPEN;
            default:     state_d = GATE_OPEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= GATE_OPEN;
        else
            state_q <= state_d;
    end

    // Request output is the asserting state.
    always_comb begin
        req = (state_q == GATE_ASSERT);
    end

    // R7: while waiting without resume, the request stays low
    a_r7_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_WAIT && !resume) |=> !req);
    // R6: a request only rises after an enabled pending cause
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(active_any));
    // R6: the request holds while a cause remains
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && active_any) |=> req);
endmodule

// File: rtl/irq_ctl_top.sv
// Module: irq_ctl_top
// Five-source host interrupt controller: register decode, pending
// flags and request gate. Assumes event inputs are synchronous to clk.
module irq_ctl_top
    import irq_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  src_evt,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] rd_data,
    output logic        cpu_irq
);
    logic [NSRC-1:0] enable_q;
    logic [NSRC-1:0] clr_strobe;
    logic [NSRC-1:0] pend_q;
    logic            resume_pulse;
    logic            active_any;

    irq_regif #(.N_SRC(NSRC), .DATA_W(REG_W), .CLR_LSB(CLR_OFS)) u_regif (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .pending      (pend_q),
        .enable_q     (enable_q),
        .clr_strobe   (clr_strobe),
        .resume_pulse (resume_pulse),
        .rdata        (rd_data)
    );

    irq_pending_bank #(.N_SRC(NSRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (src_evt),
        .clr    (clr_strobe),
        .pend_q (pend_q)
    );

    // Any source both pending and enabled.
    always_comb begin
        active_any = |(pend_q & enable_q);
    end

    irq_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_any (active_any),
        .resume     (resume_pulse),
        .req        (cpu_irq)
    );

    // R5: a disabled timer source alone never starts a request
    a_r5_timer_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq && !enable_q[SRC_TIMER] && ((pend_q & enable_q) == '0)) |=> !cpu_irq);
    // R8: a resume write leaves the pending flags alone
    a_r8_resume_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && src_evt == '0) |=> pend_q == $past(pend_q));
endmodule

// File: tb/test_irq_ctl_top.sv
module test_irq_ctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_evt = '0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] rd_data;
    logic        cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_ctl_top i_irq_ctl_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rd_data   (rd_data),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse(input logic [4:0] m);
        @(negedge clk) src_evt = m;
        @(negedge clk) src_evt = '0;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
        @(negedge clk) begin reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0; end
    endtask

    task automatic t_reset;
        check("R1 pending", rd_data, 16'h0000);
        check("R1 irq", {15'b0, cpu_irq}, 16'h0000);
    endtask

    task automatic t_pending_map;
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i));
            check("R2 map", rd_data, 16'(1 << i));
            cyc(1);
            check("R5 disabled no irq", {15'b0, cpu_irq}, 16'h0000);
            wr(1'b0, 16'(1 << (i + 8)));
            check("R3 clear", rd_data, 16'h0000);
        end
        pulse(5'b00101);
        wr(1'b0, 16'h0100);   // clear video only
        check("R3 others kept", rd_data, 16'h0004);
        wr(1'b0, 16'h0400);
        check("R3 object cleared", rd_data, 16'h0000);
    endtask

    task automatic t_set_wins;
        @(negedge clk) begin src_evt = 5'b00010; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h0200; end
        @(negedge clk) begin src_evt = '0; reg_wr = 1'b0; reg_wdata = '0; end
        check("R4 set wins", rd_data, 16'h0002);
        wr(1'b0, 16'h0200);
        check("R4 later clear", rd_data, 16'h0000);
    endtask

    task automatic t_timer_and_request;
        wr(1'b0, 16'h0017);           // all enabled except timer
        pulse(5'b01000);
        cyc(3);
        check("R5 timer gated", {15'b0, cpu_irq}, 16'h0000);
        check("R2 timer pending", rd_data, 16'h0008);
        wr(1'b0, 16'h001F);           // enable timer
        check("R6 not yet", {15'b0, cpu_irq}, 16'h0000);
        cyc(1);
        check("R6 rises", {15'b0, cpu_irq}, 16'h0001);
        cyc(3);
        check("R6 held", {15'b0, cpu_irq}, 16'h0001);
        wr(1'b0, 16'h081F);           // clear timer
        check("R6 falls one edge later", {15'b0, cpu_irq}, 16'h0001);
        cyc(1);
        check("R6 fallen", {15'b0, cpu_irq}, 16'h0000);
    endtask

    task automatic t_holdoff;
        pulse(5'b00001);
        cyc(4);
        check("R7 held off", {15'b0, cpu_irq}, 16'h0000);
        check("R7 pending seen", rd_data, 16'h0001);
        wr(1'b1, 16'hFFFF);           // resume, data ignored
        check("R8 pending kept", rd_data, 16'h0001);
        check("R7 not yet", {15'b0, cpu_irq}, 16'h0000);
        cyc(1);
        check("R7 rises after resume", {15'b0, cpu_irq}, 16'h0001);
        wr(1'b1, 16'h0000);           // resume while asserted: no effect
        check("R8 resume no effect", {15'b0, cpu_irq}, 16'h0001);
        wr(1'b0, 16'h011F);
        cyc(1);
        check("R6 cleared", {15'b0, cpu_irq}, 16'h0000);
        wr(1'b1, 16'h0000);
        pulse(5'b10000);
        cyc(1);
        check("R8 enables kept after resume", {15'b0, cpu_irq}, 16'h0001);
        wr(1'b0, 16'h1000);           // clears ext, enables all off
        cyc(2);
        check("R5 all disabled", {15'b0, cpu_irq}, 16'h0000);
    endtask

    initial begin
        cyc(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_pending_map();
        t_set_wins();
        t_timer_and_request();
        t_holdoff();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule